// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from its module clock. One control word holds two divisor fields and a mode bit. In linear mode the output period is an even count of module clocks, 2*(N+1). In power-of-two mode the output period is 2^N module clocks. In both modes the output can never run faster than half the module clock.

While the transfer engine holds `run` high, the block emits a single-cycle strobe at every half period of the serial clock and flips the serial clock level on that same cycle. The shift engine uses alternate strobes as launch and capture edges, chosen by its clock phase setting. While `run` is low, the serial clock sits at the idle level given by `cpol`, no strobes are emitted and the half-period counter is held at zero. The divisor setting is captured only while idle, so a transfer always runs with the setting it started with.

Top module: `spi_clk_div`

## Requirements
- R1: When `clk_ctl[12]` is 1 (linear mode), the half period is N+1 module clocks, where N is `clk_ctl[7:0]`, giving a serial clock period of 2*(N+1).
- R2: When `clk_ctl[12]` is 0 (power-of-two mode), the serial clock period is 2^N module clocks, where N is `clk_ctl[11:8]`, so the half period is 2^(N-1).
- R3: In power-of-two mode, N values of 0 and 1 both give divide-by-2, which is a half period of one module clock.
- R4: One clock edge after an edge that samples `run` low, `sclk` equals the `cpol` value sampled at that edge.
- R5: While `run` is low, `edge_stb` stays low and the counter clears. After `run` is raised again, the first strobe arrives one full half period later, even if the previous run stopped partway through a half period.
- R6: The first `edge_stb` pulse follows the H-th edge that samples `run` high, where H is the half period, and further pulses follow every H edges after that. `sclk` flips exactly on the cycles where `edge_stb` is high, so after the k-th strobe it equals `cpol` XOR (k odd).
- R7: The divisor setting is captured only on edges that sample `run` low. Changes to `clk_ctl` while `run` is high have no effect on strobe timing.
- R8: While reset is asserted, `edge_stb` and `sclk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ctl | input | 13 | Divisor control word: [7:0] linear N, [11:8] power-of-two N, [12] mode (1 = linear) |
| cpol | input | 1 | Idle level of the serial clock |
| run | input | 1 | High while the transfer engine wants the serial clock running |
| edge_stb | output | 1 | One-cycle pulse per serial clock half period |
| sclk | output | 1 | Serial clock level |

## Verification
Every result is registered once. A strobe appears after the H-th, 2H-th, and later edges counted from the first edge that samples `run` high. `sclk` changes in the same cycle as the strobe, and `sclk` takes the `cpol` value one edge after any idle edge. The bench changes inputs 1 ns after a falling edge. At each falling edge it compares the outputs against an edge counter that starts at the first edge sampling `run` high. The driver queues the expected strobe edge number and `sclk` level for every case, and the monitor pops one entry per observed strobe. The monitor flags strobes that were not expected, and the driver flags expected strobes still in the queue when the case ends. Idle cycles are checked for the `cpol` level and for the absence of any strobe.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
    typedef enum logic {
        DIV_POW2   = 1'b0,
        DIV_LINEAR = 1'b1
    } div_mode_e;
endpackage

// File: rtl/scd_cfg.sv
// Captures the half-period length (minus one) while the divider is idle.
module scd_cfg
    import spi_clk_div_pkg::*;
#(
    parameter int LIN_W  = 8,
    parameter int POW_W  = 4,
    parameter int HALF_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  div_mode_e         mode,
    input  logic [LIN_W-1:0]  lin_n,
    input  logic [POW_W-1:0]  pow_n,
    output logic [HALF_W-1:0] half_m1
);
    typedef struct packed {
        logic [HALF_W-1:0] half_m1;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [HALF_W-1:0] cand;

    always_comb begin
        st_d = st_q;
        if (mode == DIV_LINEAR) begin
            cand = HALF_W'(lin_n);
        end else if (pow_n <= POW_W'(1)) begin
            cand = '0;
        end else begin
            cand = (HALF_W'(1) << (pow_n - POW_W'(1))) - HALF_W'(1);
        end
        if (load) begin
            st_d.half_m1 = cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign half_m1 = st_q.half_m1;
endmodule

// File: rtl/scd_timer.sv
// Counts module clocks within a half period and flags its last cycle.
module scd_timer #(
    parameter int HALF_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_m1,
    output logic              hit,
    output logic              stb
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              stb;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        hit      = run && (st_q.cnt == half_m1);
        st_d.stb = hit;
        if (run && !hit) begin
            st_d.cnt = st_q.cnt + HALF_W'(1);
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb = st_q.stb;
endmodule

// File: rtl/scd_level.sv
// Holds the serial clock level: idle polarity when stopped, toggling when running.
module scd_level (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cpol,
    input  logic toggle,
    output logic sclk
);
    typedef struct packed {
        logic lvl;
    } lvl_t;

    lvl_t st_d, st_q;

    always_comb begin
        if (run) begin
            st_d.lvl = st_q.lvl ^ toggle;
        end else begin
            st_d.lvl = cpol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.lvl;
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
    import spi_clk_div_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int POW_W = 4,
    localparam int MODE_BIT   = LIN_W + POW_W,
    localparam int CTL_W      = MODE_BIT + 1,
    localparam int POW_MAX_M1 = (1 << POW_W) - 2,
    localparam int HALF_W     = (LIN_W > POW_MAX_M1) ? LIN_W : POW_MAX_M1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] clk_ctl,
    input  logic             cpol,
    input  logic             run,
    output logic             edge_stb,
    output logic             sclk
);
    logic [HALF_W-1:0] half_m1;
    logic              hit;
    div_mode_e         mode;

    assign mode = div_mode_e'(clk_ctl[MODE_BIT]);

    scd_cfg #(
        .LIN_W (LIN_W),
        .POW_W (POW_W),
        .HALF_W(HALF_W)
    ) i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (!run),
        .mode   (mode),
        .lin_n  (clk_ctl[LIN_W-1:0]),
        .pow_n  (clk_ctl[MODE_BIT-1:LIN_W]),
        .half_m1(half_m1)
    );

    scd_timer #(
        .HALF_W(HALF_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .half_m1(half_m1),
        .hit    (hit),
        .stb    (edge_stb)
    );

    scd_level i_level (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .cpol  (cpol),
        .toggle(hit),
        .sclk  (sclk)
    );
endmodule

// File: rtl/spi_clk_div_chk.sv
module spi_clk_div_chk #(
    parameter int HALF_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              cpol,
    input logic              edge_stb,
    input logic              sclk,
    input logic [HALF_W-1:0] half_m1
);
    // R4: idle edge drives the serial clock to the sampled polarity
    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run)) |-> (sclk == $past(cpol)));

    // R5: no strobe produced by an idle edge
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run)) |-> !edge_stb);

    // R6: while running, sclk flips exactly on strobe cycles
    p_toggle_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run)) |-> (edge_stb == (sclk != $past(sclk))));

    // R7: captured setting frozen while running
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run)) |-> $stable(half_m1));
endmodule

bind spi_clk_div spi_clk_div_chk #(.HALF_W(HALF_W)) i_spi_clk_div_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .cpol    (cpol),
    .edge_stb(edge_stb),
    .sclk    (sclk),
    .half_m1 (half_m1)
);

// File: tb/test_spi_clk_div.sv
`timescale 1ns/1ps
module test_spi_clk_div;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] clk_ctl;
    logic        cpol;
    logic        run;
    logic        edge_stb;
    logic        sclk;

    always #2.5 clk = ~clk;

    spi_clk_div i_spi_clk_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_ctl (clk_ctl),
        .cpol    (cpol),
        .run     (run),
        .edge_stb(edge_stb),
        .sclk    (sclk)
    );

    typedef struct {
        int    cyc;
        logic  lvl;
        string req;
    } exp_t;

    exp_t  q[$];
    int    tests = 0;
    int    fails = 0;
    int    cyc   = 0;
    logic  run_e  = 1'b0;
    logic  cpol_e = 1'b0;
    bit    mon_on = 1'b0;
    bit    done   = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_half(logic [12:0] c);
        if (c[12]) return int'(c[7:0]) + 1;
        else if (c[11:8] <= 4'd1) return 1;
        else return 1 << (int'(c[11:8]) - 1);
    endfunction

    // edge counter since run was first sampled high
    always @(posedge clk) begin
        run_e  <= run;
        cpol_e <= cpol;
        if (run) cyc <= cyc + 1;
        else     cyc <= 0;
    end

    // monitor: compare outputs against the expected queue
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (!run_e) begin
                chk(edge_stb == 1'b0, "R5", "idle strobe", int'(edge_stb), 0);
                chk(sclk == cpol_e, "R4", "idle level", int'(sclk), int'(cpol_e));
            end else if (edge_stb) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected strobe at edge", cyc, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.cyc, e.req, "strobe edge", cyc, e.cyc);
                    chk(sclk == e.lvl, "R6", "sclk after strobe", int'(sclk), int'(e.lvl));
                end
            end
        end
    end

    // driver: n strobes expected, tail extra edges before stopping
    task automatic run_case(logic [12:0] c, logic pol, int n, int tail, string req,
                            bit use_mid, logic [12:0] mid);
        int h;
        @(negedge clk); #1;
        clk_ctl = c;
        cpol    = pol;
        repeat (3) @(negedge clk);
        h = exp_half(c);
        for (int k = 1; k <= n; k++) begin
            exp_t e;
            e.cyc = k * h;
            e.lvl = pol ^ logic'(k % 2);
            e.req = req;
            q.push_back(e);
        end
        #1 run = 1'b1;
        for (int i = 0; i < n * h + tail; i++) begin
            @(negedge clk);
            if (i == 0 && use_mid) begin
                #1 clk_ctl = mid;
            end
        end
        #1 run = 1'b0;
        repeat (3) @(negedge clk);
        chk(q.size() == 0, req, "missing strobes", q.size(), 0);
        q.delete();
    endtask

    initial begin
        rst_n   = 1'b0;
        run     = 1'b0;
        cpol    = 1'b1;
        clk_ctl = 13'h0;
        repeat (3) @(negedge clk);
        chk(edge_stb == 1'b0, "R8", "reset strobe", int'(edge_stb), 0);
        chk(sclk == 1'b0, "R8", "reset sclk", int'(sclk), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        run_case(13'h1000, 1'b0, 6, 0, "R1", 1'b0, 13'h0);      // linear N=0
        run_case(13'h1002, 1'b1, 5, 0, "R1", 1'b0, 13'h0);      // linear N=2
        run_case(13'h10FF, 1'b0, 4, 0, "R1", 1'b0, 13'h0);      // linear N=255
        run_case(13'h0000, 1'b1, 5, 0, "R3", 1'b0, 13'h0);      // pow N=0
        run_case(13'h0100, 1'b0, 5, 0, "R3", 1'b0, 13'h0);      // pow N=1
        run_case(13'h0300, 1'b1, 4, 0, "R2", 1'b0, 13'h0);      // pow N=3
        run_case(13'h0A00, 1'b0, 2, 0, "R2", 1'b0, 13'h0);      // pow N=10
        run_case(13'h0F00, 1'b1, 2, 0, "R2", 1'b0, 13'h0);      // pow N=15
        run_case(13'h1205, 1'b0, 3, 0, "R1", 1'b0, 13'h0);      // both fields, linear
        run_case(13'h0205, 1'b0, 3, 0, "R2", 1'b0, 13'h0);      // both fields, pow
        run_case(13'h1003, 1'b0, 4, 0, "R7", 1'b1, 13'h1000);   // change while running
        run_case(13'h1007, 1'b1, 1, 4, "R5", 1'b0, 13'h0);      // stop mid half period
        run_case(13'h1007, 1'b1, 3, 0, "R5", 1'b0, 13'h0);      // restart from zero
        run_case(13'h0000, 1'b0, 3, 0, "R6", 1'b0, 13'h0);      // back-to-back strobes

        mon_on = 1'b0;
        done   = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule